// File: doc/BRIEF.md
# ULPI Link Register Access Engine

This block is the link-side sequencer that reads and writes PHY registers over an 8-bit ULPI bus. The bus has a data byte, a direction line owned by the PHY (`ulpi_dir`), a byte-accept strobe from the PHY (`ulpi_nxt`) and a stop strobe from the link (`ulpi_stp`). All of these are synchronous to the PHY clock. A host-side request port supplies the operation type, an 8-bit register address and the write data. The engine answers with a single-cycle done pulse and, for reads, the captured byte.

Addresses below 0x2F use the short form, where the address rides inside the command byte. Any address of 0x2F or above uses the long form. In the long form the command byte carries the escape code 0x2F, and a separate address byte follows it. The PHY may take the bus at any time by raising `ulpi_dir`. When that happens during an operation, the engine stops driving, waits for the bus to come back, and reissues the whole operation from its command byte. It repeats this until the operation completes. Receive traffic itself is not decoded.

Top module: `ulpi_regacc`

## Requirements
- R1: A request is accepted (`req_ready` high) only while the engine is idle and `ulpi_dir` is low. A request presented while `ulpi_dir` is high starts nothing.
- R2: For an address below 0x2F, the first byte driven is the command byte. Bits [7:6] hold 2'b10 for a write and 2'b11 for a read, and bits [5:0] hold the address.
- R3: For an address of 0x2F or above, the command byte carries 6'h2F in bits [5:0]. It is followed by a byte holding the full 8-bit address.
- R4: Each byte the link drives stays unchanged on the data lines until the PHY answers with `ulpi_nxt` high.
- R5: In a read, the link stops driving after the last request byte is accepted. It treats the cycle in which `ulpi_dir` is first seen high as turnaround. It captures the data byte in the next cycle and presents it on `rsp_rdata` together with `rsp_done` one cycle later.
- R6: `ulpi_data_oe` is low in every cycle in which `ulpi_dir` is high.
- R7: If `ulpi_dir` rises while a command, address or write-data byte is pending, the operation is abandoned. Once `ulpi_dir` falls, it is reissued from the command byte, with the same bytes.
- R8: `rsp_done` is a one-cycle pulse, given only after a successful operation and never for an abandoned attempt.
- R9: After the final write byte is accepted, `ulpi_stp` is high for exactly one cycle with the data lines at zero. Done follows in the next cycle. After reset, `ulpi_stp`, `ulpi_data_oe` and `rsp_done` are low.
- R10: If, while the link waits for read data, `ulpi_dir` rises together with `ulpi_nxt`, the read is abandoned and retried as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Engine can accept a request this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| ulpi_dir | input | 1 | Bus direction, high when the PHY drives |
| ulpi_nxt | input | 1 | PHY accepts the byte / throttles |
| ulpi_stp | output | 1 | Link stop strobe |
| ulpi_data_i | input | 8 | Data lines as driven by the PHY |
| ulpi_data_o | output | 8 | Data lines as driven by the link |
| ulpi_data_oe | output | 1 | Link drives the data lines |

## Verification
The properties in the checker cover the rules that apply in every cycle:
- the link never drives while `ulpi_dir` is high;
- a driven byte holds until `ulpi_nxt`;
- the stop cycle shows zero data;
- readiness implies `ulpi_dir` low;
- done is a single pulse that follows either a stop cycle or a PHY-driven data cycle.

Only the bench scenarios can show the rest:
- the exact byte order for each addressing form;
- that a retried attempt repeats identical bytes;
- that the captured read byte is the one present in the cycle after turnaround;
- that abandoned attempts give no done.

The bench sweeps both addressing forms, both directions, several throttle depths and every abort point.

// File: rtl/ulpi_regacc_pkg.sv
package ulpi_regacc_pkg;

    localparam int BYTE_W = 8;
    localparam int IMM_W  = 6;
    localparam int OP_W   = BYTE_W - IMM_W;

    localparam logic [IMM_W-1:0] EXT_ESC = 6'h2F;
    localparam logic [OP_W-1:0]  OP_WR   = 2'b10;
    localparam logic [OP_W-1:0]  OP_RD   = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_STOP,
        ST_RWAIT,
        ST_RDATA,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic              ext;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } reg_op_t;

    function automatic logic needs_ext(input logic [BYTE_W-1:0] a);
        return a >= {{OP_W{1'b0}}, EXT_ESC};
    endfunction

    function automatic logic [BYTE_W-1:0] cmd_byte(input reg_op_t op);
        logic [OP_W-1:0]  opc;
        logic [IMM_W-1:0] fld;
        opc = op.wr  ? OP_WR : OP_RD;
        fld = op.ext ? EXT_ESC : op.addr[IMM_W-1:0];
        return {opc, fld};
    endfunction

endpackage

// File: rtl/ulpi_regacc_req.sv
module ulpi_regacc_req
    import ulpi_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              i_wr,
    input  logic [BYTE_W-1:0] i_addr,
    input  logic [BYTE_W-1:0] i_wdata,
    output reg_op_t           op_q,
    output logic [BYTE_W-1:0] cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (load) begin
            op_q.wr    <= i_wr;
            op_q.ext   <= needs_ext(i_addr);
            op_q.addr  <= i_addr;
            op_q.wdata <= i_wdata;
        end
    end

    assign cmd = cmd_byte(op_q);
endmodule

// File: rtl/ulpi_regacc_seq.sv
module ulpi_regacc_seq
    import ulpi_regacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  reg_op_t    op,
    input  logic       dir,
    input  logic       nxt,
    output seq_state_e state,
    output logic       complete,
    output logic       capture
);
    seq_state_e nstate;

    always_comb begin
        nstate   = state;
        complete = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_CMD;
            ST_CMD: begin
                if (dir)      nstate = ST_HOLD;
                else if (nxt) nstate = op.ext ? ST_ADDR
                                     : (op.wr ? ST_WDATA : ST_RWAIT);
            end
            ST_ADDR: begin
                if (dir)      nstate = ST_HOLD;
                else if (nxt) nstate = op.wr ? ST_WDATA : ST_RWAIT;
            end
            ST_WDATA: begin
                if (dir)      nstate = ST_HOLD;
                else if (nxt) nstate = ST_STOP;
            end
            ST_STOP: begin
                nstate   = ST_IDLE;
                complete = 1'b1;
            end
            ST_RWAIT: begin
                if (dir) nstate = nxt ? ST_HOLD : ST_RDATA;
            end
            ST_RDATA: begin
                if (dir) begin
                    nstate   = ST_IDLE;
                    complete = 1'b1;
                    capture  = 1'b1;
                end else begin
                    nstate = ST_HOLD;
                end
            end
            ST_HOLD:  if (!dir) nstate = ST_CMD;
            default:  nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end
endmodule

// File: rtl/ulpi_regacc_io.sv
module ulpi_regacc_io
    import ulpi_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  reg_op_t           op,
    input  logic [BYTE_W-1:0] cmd,
    input  logic              dir,
    input  logic              complete,
    input  logic              capture,
    input  logic [BYTE_W-1:0] data_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              data_oe,
    output logic              stp,
    output logic              done,
    output logic [BYTE_W-1:0] rdata
);
    logic drive_st;

    always_comb begin
        data_o   = '0;
        drive_st = 1'b1;
        unique case (state)
            ST_CMD:   data_o = cmd;
            ST_ADDR:  data_o = op.addr;
            ST_WDATA: data_o = op.wdata;
            ST_STOP:  data_o = '0;
            default:  drive_st = 1'b0;
        endcase
    end

    assign data_oe = drive_st & ~dir;
    assign stp     = (state == ST_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= complete;
            if (capture) rdata <= data_i;
        end
    end
endmodule

// File: rtl/ulpi_regacc.sv
module ulpi_regacc
    import ulpi_regacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       req_ready,
    output logic       rsp_done,
    output logic [7:0] rsp_rdata,
    input  logic       ulpi_dir,
    input  logic       ulpi_nxt,
    output logic       ulpi_stp,
    input  logic [7:0] ulpi_data_i,
    output logic [7:0] ulpi_data_o,
    output logic       ulpi_data_oe
);
    seq_state_e        state;
    reg_op_t           op;
    logic [BYTE_W-1:0] cmd;
    logic              start, complete, capture;

    assign req_ready = (state == ST_IDLE) && !ulpi_dir;
    assign start     = req_valid && req_ready;

    ulpi_regacc_req u_req (
        .clk(clk), .rst(rst), .load(start),
        .i_wr(req_write), .i_addr(req_addr), .i_wdata(req_wdata),
        .op_q(op), .cmd(cmd)
    );

    ulpi_regacc_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .dir(ulpi_dir), .nxt(ulpi_nxt),
        .state(state), .complete(complete), .capture(capture)
    );

    ulpi_regacc_io u_io (
        .clk(clk), .rst(rst), .state(state), .op(op), .cmd(cmd),
        .dir(ulpi_dir), .complete(complete), .capture(capture),
        .data_i(ulpi_data_i), .data_o(ulpi_data_o), .data_oe(ulpi_data_oe),
        .stp(ulpi_stp), .done(rsp_done), .rdata(rsp_rdata)
    );
endmodule

// File: rtl/ulpi_regacc_chk.sv
module ulpi_regacc_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       ulpi_dir,
    input logic       ulpi_nxt,
    input logic       ulpi_stp,
    input logic [7:0] ulpi_data_o,
    input logic       ulpi_data_oe
);
    a_r6_no_drive_under_dir: assert property (@(posedge clk) disable iff (rst)
        ulpi_dir |-> !ulpi_data_oe);

    a_r1_ready_needs_dir_low: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !ulpi_dir);

    a_r4_byte_held: assert property (@(posedge clk) disable iff (rst)
        (ulpi_data_oe && !ulpi_nxt && !ulpi_stp) |=> (!ulpi_data_oe || $stable(ulpi_data_o)));

    a_r9_stop_zero_data: assert property (@(posedge clk) disable iff (rst)
        ulpi_stp |-> (ulpi_data_o == 8'h00));

    a_r9_stop_single: assert property (@(posedge clk) disable iff (rst)
        ulpi_stp |=> !ulpi_stp);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r8_done_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_done) |-> ($past(ulpi_stp) || $past(ulpi_dir)));
endmodule

bind ulpi_regacc ulpi_regacc_chk u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_stp(ulpi_stp),
    .ulpi_data_o(ulpi_data_o), .ulpi_data_oe(ulpi_data_oe)
);

// File: tb/ulpi_regacc_tb_top.sv
`timescale 1ns/1ps
module ulpi_regacc_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_write;
    logic [7:0] req_addr, req_wdata;
    logic       req_ready, rsp_done;
    logic [7:0] rsp_rdata;
    logic       ulpi_dir, ulpi_nxt, ulpi_stp, ulpi_data_oe;
    logic [7:0] ulpi_data_i, ulpi_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ulpi_regacc dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_stp(ulpi_stp),
        .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
        .ulpi_data_oe(ulpi_data_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drives one request and plays the PHY. abort_at: byte index at which the
    // PHY grabs the bus on the first attempt; nb = read receive-abort; -1 none.
    task automatic run_op(input bit w, input logic [7:0] a, input logic [7:0] wd,
                          input logic [7:0] rd, input int dly, input int abort_at);
        logic [7:0] seqb [3];
        int   nb;
        bit   ext, aborted, restart, ok;
        string tag;
        ext = (a >= 8'h2F);
        tag = ext ? "R3" : "R2";
        seqb[0] = {w ? 2'b10 : 2'b11, ext ? 6'h2F : a[5:0]};
        nb = 1;
        if (ext) begin seqb[nb] = a; nb++; end
        if (w)   begin seqb[nb] = wd; nb++; end

        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        #1 chk(req_ready == 1'b1, "R1", req_ready, 1);
        cyc();
        req_valid = 1'b0;
        aborted = 0;
        ok = 0;
        while (!ok) begin
            restart = 0;
            for (int i = 0; i < nb && !restart; i++) begin
                for (int k = 0; k < dly; k++) begin
                    #1 chk(ulpi_data_oe && ulpi_data_o == seqb[i], "R4", ulpi_data_o, seqb[i]);
                    cyc();
                end
                if (!aborted && abort_at == i) begin
                    ulpi_dir = 1'b1; ulpi_nxt = 1'b0;
                    #1 chk(!ulpi_data_oe, "R6", ulpi_data_oe, 0);
                    for (int k = 0; k < 2; k++) begin
                        cyc();
                        #1 chk(!rsp_done && !ulpi_data_oe, "R7", rsp_done, 0);
                    end
                    ulpi_dir = 1'b0;
                    cyc();
                    aborted = 1; restart = 1;
                end else begin
                    ulpi_nxt = 1'b1;
                    #1 chk(ulpi_data_oe && ulpi_data_o == seqb[i], aborted ? "R7" : tag,
                           ulpi_data_o, seqb[i]);
                    cyc();
                    ulpi_nxt = 1'b0;
                end
            end
            if (restart) continue;
            if (w) begin
                #1 chk(ulpi_stp && ulpi_data_o == 8'h00, "R9", ulpi_data_o, 0);
                chk(!rsp_done, "R8", rsp_done, 0);
                cyc();
                #1 chk(rsp_done && !ulpi_stp, "R9", {ulpi_stp, rsp_done}, 1);
                ok = 1;
            end else begin
                #1 chk(!ulpi_data_oe, "R5", ulpi_data_oe, 0);
                if (!aborted && abort_at == nb) begin
                    ulpi_dir = 1'b1; ulpi_nxt = 1'b1;
                    cyc();
                    ulpi_nxt = 1'b0;
                    cyc();
                    #1 chk(!rsp_done, "R10", rsp_done, 0);
                    ulpi_dir = 1'b0;
                    cyc();
                    aborted = 1;
                    continue;
                end
                ulpi_dir = 1'b1; ulpi_data_i = ~rd;
                #1 chk(!ulpi_data_oe, "R6", ulpi_data_oe, 0);
                cyc();
                ulpi_data_i = rd;
                #1 chk(!rsp_done, "R5", rsp_done, 0);
                cyc();
                ulpi_dir = 1'b0; ulpi_data_i = 8'h00;
                #1 chk(rsp_done && rsp_rdata == rd, "R5", rsp_rdata, rd);
                ok = 1;
            end
        end
        cyc();
        #1 chk(!rsp_done, "R8", rsp_done, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] addrs [4];
        addrs[0] = 8'h05; addrs[1] = 8'h2E; addrs[2] = 8'h2F; addrs[3] = 8'hC3;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_data_i = '0;
        repeat (3) cyc();
        rst = 1'b0;
        #1;
        chk(!ulpi_data_oe && !ulpi_stp && !rsp_done, "R9", {ulpi_data_oe, ulpi_stp, rsp_done}, 0);
        chk(req_ready, "R1", req_ready, 1);
        cyc();

        // R1: request while PHY owns the bus must not start anything
        ulpi_dir = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h11;
        #1 chk(!req_ready, "R1", req_ready, 0);
        cyc();
        req_valid = 1'b0; ulpi_dir = 1'b0;
        #1 chk(!ulpi_data_oe && req_ready, "R1", ulpi_data_oe, 0);
        cyc();
        #1 chk(!ulpi_data_oe && !rsp_done, "R1", ulpi_data_oe, 0);
        cyc();

        for (int w = 0; w < 2; w++)
            for (int ai = 0; ai < 4; ai++)
                for (int d = 0; d < 3; d++)
                    for (int ab = -1; ab < 3; ab++) begin
                        run_op(w[0], addrs[ai], 8'h3C ^ addrs[ai] ^ 8'(d),
                               8'hA5 ^ addrs[ai] ^ 8'(ab + d), d, ab);
                        cyc();
                    end
        summary();
    end
endmodule